// File: doc/BRIEF.md
# Port Change Interrupt Detector

This block watches the high half of an 8-bit general-purpose port and reports when a pin that is set up as an input no longer matches the level it had the last time software accessed the port. Each read or write of the port takes a new snapshot of the watched pins. Each cycle, every watched input is compared with its snapshot, and the per-pin differences are ORed into one sticky change flag.

Because the compare is against a snapshot and does not look for edges, the flag sets itself again on every clock while a difference remains. Software clears it in two steps. First it accesses the port, which refreshes the snapshot. Then it writes the clear. An enable bit gates the interrupt request but has no effect on the flag. A wake request comes straight from the compare logic, so it works while the clock is stopped in sleep.

Top module: `port_change_detect`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the flag and the interrupt request are 0. The snapshot holds the pin levels present at reset, so nonzero pins at reset give no flag once reset is released.
- R2: A watched pin (bits 7:4) whose direction bit is 1 (input) and whose level differs from its snapshot sets chg_flag at the next clock edge.
- R3: Level changes on bits 3:0 never set the flag.
- R4: A watched pin whose direction bit is 0 (output) is left out of the compare.
- R5: A cycle with port_rd or port_wr high loads the snapshot with that cycle's levels on bits 7:4. From the next cycle, those levels no longer count as a difference.
- R6: flag_clr has no effect while a difference is present: the flag stays 1.
- R7: flag_clr with no difference present gives chg_flag = 0 after the edge.
- R8: When flag_clr and a difference fall in the same cycle, setting wins over clearing.
- R9: chg_irq is chg_flag gated by irq_en. irq_en has no effect on chg_flag.
- R10: wake_req is high in the same cycle as a difference when irq_en is 1, with no clock edge needed. It is low when irq_en is 0.
- R11: Once set, the flag stays 1 after the pins return to their snapshot values, until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_sync | input | 8 | Synchronized pin levels |
| dir_in | input | 8 | Direction bits, 1 = input, 0 = output |
| port_rd | input | 1 | Port read strobe |
| port_wr | input | 1 | Port write strobe |
| flag_clr | input | 1 | Write that clears the flag |
| irq_en | input | 1 | Enables the interrupt request and wake request |
| chg_flag | output | 1 | Sticky change flag |
| chg_irq | output | 1 | Interrupt request |
| wake_req | output | 1 | Combinational wake request |

## Verification
The bench tries to clear the flag while a difference is still present. A design that let the clear win would drop the flag even though the pins still disagree with the snapshot. It refreshes the snapshot with a read and, separately, with a write. A design that ignored one of the strobes would keep re-flagging forever after that kind of access. It changes only the low bits, and pins set as outputs, to catch a compare mask that is too wide. It also changes a pin between clock edges to show that the wake request does not wait for a clock. Finally, it resets with nonzero pins to catch a snapshot that resets to a constant and raises a false flag.

// File: rtl/ioc_pkg.sv
package ioc_pkg;
    localparam int IOC_PORT_W = 8;
    localparam int IOC_MON_LO = 4;

    typedef enum logic [1:0] {
        FLAG_HOLD  = 2'd0,
        FLAG_SET   = 2'd1,
        FLAG_CLEAR = 2'd2
    } flag_act_e;
endpackage

// File: rtl/ioc_snap_next.sv
module ioc_snap_next #(
    parameter int W = 4
) (
    input  logic         capture,
    input  logic [W-1:0] pins,
    input  logic [W-1:0] snap_q,
    output logic [W-1:0] snap_d
);
    always_comb begin
        snap_d = capture ? pins : snap_q;
    end
endmodule

// File: rtl/ioc_compare.sv
module ioc_compare #(
    parameter int W = 4
) (
    input  logic [W-1:0] pins,
    input  logic [W-1:0] snap,
    input  logic [W-1:0] is_input,
    output logic         differ
);
    logic [W-1:0] bit_miss;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_miss[i] = is_input[i] & (pins[i] ^ snap[i]);
    end

    assign differ = |bit_miss;
endmodule

// File: rtl/ioc_flag_next.sv
module ioc_flag_next
    import ioc_pkg::*;
(
    input  logic      flag_q,
    input  logic      set_req,
    input  logic      clr_req,
    output flag_act_e action,
    output logic      flag_d
);
    always_comb begin
        if (set_req)      action = FLAG_SET;
        else if (clr_req) action = FLAG_CLEAR;
        else              action = FLAG_HOLD;

        unique case (action)
            FLAG_SET:   flag_d = 1'b1;
            FLAG_CLEAR: flag_d = 1'b0;
            default:    flag_d = flag_q;
        endcase
    end
endmodule

// File: rtl/port_change_detect.sv
module port_change_detect
    import ioc_pkg::*;
#(
    parameter int PORT_W = IOC_PORT_W,
    parameter int MON_LO = IOC_MON_LO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] pin_sync,
    input  logic [PORT_W-1:0] dir_in,
    input  logic              port_rd,
    input  logic              port_wr,
    input  logic              flag_clr,
    input  logic              irq_en,
    output logic              chg_flag,
    output logic              chg_irq,
    output logic              wake_req
);
    localparam int MON_W = PORT_W - MON_LO;

    typedef struct packed {
        logic [MON_W-1:0] snap;
        logic             flag;
    } state_t;

    state_t    st_q, st_d;
    logic      differ;
    logic      access;
    logic      flag_nx;
    logic [MON_W-1:0] snap_nx;
    flag_act_e act;

    wire [MON_W-1:0] pin_mon = pin_sync[PORT_W-1:MON_LO];
    wire [MON_W-1:0] dir_mon = dir_in[PORT_W-1:MON_LO];

    assign access = port_rd | port_wr;

    ioc_snap_next #(.W(MON_W)) u_snap (
        .capture (access),
        .pins    (pin_mon),
        .snap_q  (st_q.snap),
        .snap_d  (snap_nx)
    );

    ioc_compare #(.W(MON_W)) u_cmp (
        .pins     (pin_mon),
        .snap     (st_q.snap),
        .is_input (dir_mon),
        .differ   (differ)
    );

    ioc_flag_next u_flag (
        .flag_q  (st_q.flag),
        .set_req (differ),
        .clr_req (flag_clr),
        .action  (act),
        .flag_d  (flag_nx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.snap = snap_nx;
        st_d.flag = flag_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.snap <= pin_mon;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chg_flag = st_q.flag;
    assign chg_irq  = st_q.flag & irq_en;
    assign wake_req = differ & irq_en;
endmodule

// File: rtl/port_change_detect_chk.sv
module port_change_detect_chk #(
    parameter int PORT_W = 8,
    parameter int MON_LO = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PORT_W-1:0] pin_sync,
    input logic [PORT_W-1:0] dir_in,
    input logic              port_rd,
    input logic              port_wr,
    input logic              flag_clr,
    input logic              irq_en,
    input logic              chg_flag,
    input logic              chg_irq,
    input logic [PORT_W-MON_LO-1:0] snap
);
    wire [PORT_W-MON_LO-1:0] miss =
        (pin_sync[PORT_W-1:MON_LO] ^ snap) & dir_in[PORT_W-1:MON_LO];

    // R2
    diff_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|miss) |=> chg_flag);

    // R5
    access_loads_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd || port_wr) |=> (snap == $past(pin_sync[PORT_W-1:MON_LO])));

    // R7
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !(|miss)) |=> !chg_flag);

    // R11
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_flag && !flag_clr) |=> chg_flag);

    // R9
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !chg_irq);
endmodule

bind port_change_detect port_change_detect_chk #(.PORT_W(PORT_W), .MON_LO(MON_LO)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_sync (pin_sync),
    .dir_in   (dir_in),
    .port_rd  (port_rd),
    .port_wr  (port_wr),
    .flag_clr (flag_clr),
    .irq_en   (irq_en),
    .chg_flag (chg_flag),
    .chg_irq  (chg_irq),
    .snap     (st_q.snap)
);

// File: tb/sim_port_change_detect.sv
`timescale 1ns/100ps
module sim_port_change_detect;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_sync = 8'hA0;
    logic [7:0] dir_in = 8'hFF;
    logic       port_rd = 1'b0, port_wr = 1'b0, flag_clr = 1'b0, irq_en = 1'b0;
    logic       chg_flag, chg_irq, wake_req;

    int n_run = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    port_change_detect u0 (
        .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .dir_in(dir_in),
        .port_rd(port_rd), .port_wr(port_wr), .flag_clr(flag_clr),
        .irq_en(irq_en), .chg_flag(chg_flag), .chg_irq(chg_irq),
        .wake_req(wake_req)
    );

    typedef struct packed {
        logic [7:0] pins;
        logic [7:0] dir;
        logic       rd, wr, clr, en;
        logic       fl, ir;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{8'hA0, 8'hFF, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd1},  // R1 idle after reset
        '{8'hAF, 8'hFF, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd3},  // R3 low bits only
        '{8'hB0, 8'hEF, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd4},  // R4 bit4 is output
        '{8'hB0, 8'hFF, 1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0, 4'd2},  // R2 bit4 input now
        '{8'hA0, 8'hFF, 1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0, 4'd11}, // R11 pins back, sticky
        '{8'hA0, 8'hFF, 1'b0,1'b0,1'b0,1'b1, 1'b1,1'b1, 4'd9},  // R9 enable -> irq
        '{8'hB0, 8'hFF, 1'b0,1'b0,1'b1,1'b1, 1'b1,1'b1, 4'd8},  // R8 / R6 clear vs diff
        '{8'hB0, 8'hFF, 1'b1,1'b0,1'b0,1'b1, 1'b1,1'b1, 4'd5},  // R5 read captures
        '{8'hB0, 8'hFF, 1'b0,1'b0,1'b1,1'b1, 1'b0,1'b0, 4'd7},  // R7 clear sticks
        '{8'hB0, 8'hFF, 1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0, 4'd5},  // R5 no diff after read
        '{8'h30, 8'hFF, 1'b0,1'b1,1'b0,1'b0, 1'b1,1'b0, 4'd5},  // R5 write captures
        '{8'h30, 8'hFF, 1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0, 4'd7},  // R7 clear after write
        '{8'hF0, 8'h0F, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd4},  // R4 all watched outputs
        '{8'h70, 8'h7F, 1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0, 4'd2},  // R2 bit6 input differs
        '{8'h30, 8'hFF, 1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0, 4'd7}   // R7 back to snapshot
    };

    task automatic check(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    initial begin : watchdog
        #200000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        // R1: reset with pins A0, flag must be 0
        repeat (3) @(posedge clk);
        #1 check("R1 flag in reset", chg_flag, 1'b0);
        check("R1 irq in reset", chg_irq, 1'b0);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            pin_sync = VEC[i].pins;  dir_in  = VEC[i].dir;
            port_rd  = VEC[i].rd;    port_wr = VEC[i].wr;
            flag_clr = VEC[i].clr;   irq_en  = VEC[i].en;
            @(posedge clk);
            #1;
            check($sformatf("R%0d vec%0d flag", VEC[i].req, i), chg_flag, VEC[i].fl);
            check($sformatf("R%0d vec%0d irq", VEC[i].req, i), chg_irq, VEC[i].ir);
        end

        // R10: wake without clock edge; snapshot is 3, pins 30
        @(negedge clk);
        port_rd = 0; port_wr = 0; flag_clr = 0; irq_en = 1'b1; dir_in = 8'hFF;
        #0.5 check("R10 wake idle", wake_req, 1'b0);
        pin_sync = 8'h80;
        #0.5 check("R10 wake same cycle", wake_req, 1'b1);
        irq_en = 1'b0;
        #0.5 check("R10 wake disabled", wake_req, 1'b0);
        @(posedge clk); #1;
        check("R9 flag without enable", chg_flag, 1'b1);
        check("R9 irq without enable", chg_irq, 1'b0);

        // R1: reset again with nonzero pins, then no flag
        @(negedge clk);
        rst_n = 1'b0; pin_sync = 8'h50;
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1 check("R1 no flag after reset with pins 50", chg_flag, 1'b0);

        // R6: clear held across several cycles while difference persists
        @(negedge clk) pin_sync = 8'h40; flag_clr = 1'b1;
        repeat (3) @(posedge clk);
        #1 check("R6 clear ignored during diff", chg_flag, 1'b1);
        @(negedge clk) flag_clr = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule